// File: doc/BRIEF.md
# Subsampling Reference-Frame DRAM Sequencer

This block is the timing heart of a camera-side change detector. It runs on the video decoder's pixel clock and keeps only a grid of pixels: every HDIV-th valid pixel of every VDIV-th line. For each kept pixel it runs one multiplexed DRAM access. The row address goes out with the row strobe, and the column address follows with both strobes low. That access either reads the stored reference pixel or overwrites it with live data. On a read it also pulses a strobe to the difference lookup memory, which takes the live and the stored byte as its address.

A CAS-before-RAS refresh runs once per line, after each line sync. If the line sync arrives while a pixel access is still waiting or in flight, the refresh waits until the access ends. The host keeps the reference up to date by pulsing a request. The whole frame that follows the next frame sync is then written instead of read.

The line sync must not share a cycle with a valid pixel, and HDIV must be at least 4.

Top module: `vid_ref_seq`

## Requirements
- R1: During and right after reset all three DRAM strobes are high (inactive), the lookup read strobe is low and no reference capture is active.
- R2: A pixel is kept when pixel-valid is high, neither sync is high, its column index (valid pixels since the last line or frame sync) is a multiple of HDIV and its line index (line syncs since the last frame sync) is a multiple of VDIV. The DRAM row address is line index / VDIV and the column address is column index / HDIV.
- R3: Row phase. Two clock edges after the edge that samples a kept pixel (if the sequencer is free), ras_n is low, cas_n is high and the address bus carries the row address.
- R4: Column phase. On the next cycle ras_n and cas_n are both low and the address bus carries the column address. On the cycle after that, both strobes return high.
- R5: Outside a capture frame, the column phase keeps we_n high and raises the lookup read strobe for that single cycle.
- R6: Inside a capture frame, the column phase drives we_n low and keeps the lookup read strobe low.
- R7: Each line sync is followed by a refresh: one cycle with cas_n low and ras_n high, then one cycle with both low, with we_n high throughout.
- R8: A pixel access that is waiting has priority over a refresh. A refresh that is due while an access is in progress starts only after the column phase, and no refresh is lost.
- R9: A request pulse arms a capture. The next frame sync turns capture on (ref_busy_o high) for exactly one frame, until the following frame sync. A request in the same cycle as a frame sync arms the following frame instead.
- R10: we_n is low and the lookup strobe is high only in a column phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock from the video decoder |
| rst_ni | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Active video pixel in this cycle |
| hsync_i | input | 1 | One-cycle line sync pulse |
| vsync_i | input | 1 | One-cycle frame sync pulse |
| ref_req_i | input | 1 | Host request to capture a new reference frame |
| dram_addr_o | output | max(COLW,ROWW) | Multiplexed DRAM address (row, then column) |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| lut_rd_o | output | 1 | Read strobe to the difference lookup memory |
| ref_busy_o | output | 1 | Capture frame in progress |

## Verification
The case to test is a line sync that arrives while a pixel access is queued or running. The refresh it requests and the pixel access would then want the strobes in the same cycles. Lines of exactly five valid pixels with the sync right after the last one produce this case: the last kept pixel is still being served when the sync arrives. A cycle-by-cycle model then checks three things. The column phase finishes untouched. The CBR pair follows with no strobe overlap. The number of refreshes seen on the pins equals the number of line syncs.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ROW,
    SQ_COL,
    SQ_CBR1,
    SQ_CBR2
  } sq_state_e;

  // true when a running index falls on the subsampling grid
  function automatic bit samp_hit(input int unsigned idx, input int unsigned div);
    return (idx % div) == 0;
  endfunction

  // position of an index in the subsampled image
  function automatic int unsigned samp_idx(input int unsigned idx, input int unsigned div);
    return idx / div;
  endfunction

endpackage

// File: rtl/vrs_scan_ctr.sv
module vrs_scan_ctr #(
  parameter int HDIV = 4,
  parameter int VDIV = 4,
  parameter int COLW = 8,
  parameter int ROWW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_valid_i,
  input  logic            hsync_i,
  input  logic            vsync_i,
  output logic            kept_o,
  output logic [COLW-1:0] col_o,
  output logic [ROWW-1:0] row_o
);
  localparam int HCW = COLW + $clog2(HDIV);
  localparam int VCW = ROWW + $clog2(VDIV);

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (vsync_i) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hsync_i) begin
      hcnt <= '0;
      vcnt <= vcnt + 1'b1;
    end else if (pix_valid_i) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign kept_o = pix_valid_i && !hsync_i && !vsync_i &&
                  vrs_pkg::samp_hit(int'(hcnt), HDIV) &&
                  vrs_pkg::samp_hit(int'(vcnt), VDIV);
  assign col_o  = COLW'(vrs_pkg::samp_idx(int'(hcnt), HDIV));
  assign row_o  = ROWW'(vrs_pkg::samp_idx(int'(vcnt), VDIV));

  // R2: a line sync always restarts the column index at a kept position
  p_col_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i || vsync_i) |=> (col_o == '0));

endmodule

// File: rtl/vrs_ref_ctl.sv
module vrs_ref_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic ref_req_i,
  output logic wr_frame_o
);
  logic armed;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed      <= 1'b0;
      wr_frame_o <= 1'b0;
    end else if (vsync_i) begin
      wr_frame_o <= armed;
      armed      <= ref_req_i;
    end else if (ref_req_i) begin
      armed <= 1'b1;
    end
  end

  p_capture_start_on_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_frame_o) |-> $past(vsync_i));
  p_capture_end_on_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_frame_o) |-> $past(vsync_i));

endmodule

// File: rtl/vrs_dram_seq.sv
module vrs_dram_seq #(
  parameter int COLW = 8,
  parameter int ROWW = 8,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kept_i,
  input  logic [COLW-1:0] col_i,
  input  logic [ROWW-1:0] row_i,
  input  logic            wr_i,
  input  logic            hsync_i,
  output logic [AW-1:0]   addr_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic            lut_rd_o,
  output logic            start_pix_o,
  output logic            start_rf_o
);
  import vrs_pkg::*;

  sq_state_e       state;
  logic            pix_pend, pend_wr, rf_pend, cur_wr;
  logic [COLW-1:0] pend_col, cur_col;
  logic [ROWW-1:0] pend_row, cur_row;

  assign start_pix_o = (state == SQ_IDLE) && pix_pend;
  assign start_rf_o  = (state == SQ_IDLE) && !pix_pend && rf_pend;

  // pending slots: a new request in the same edge wins over the clear
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pix_pend <= 1'b0;
      pend_wr  <= 1'b0;
      pend_col <= '0;
      pend_row <= '0;
      rf_pend  <= 1'b0;
    end else begin
      if (kept_i) begin
        pix_pend <= 1'b1;
        pend_wr  <= wr_i;
        pend_col <= col_i;
        pend_row <= row_i;
      end else if (start_pix_o) begin
        pix_pend <= 1'b0;
      end
      if (hsync_i)         rf_pend <= 1'b1;
      else if (start_rf_o) rf_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state   <= SQ_IDLE;
      cur_wr  <= 1'b0;
      cur_col <= '0;
      cur_row <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_pix_o) begin
            state   <= SQ_ROW;
            cur_wr  <= pend_wr;
            cur_col <= pend_col;
            cur_row <= pend_row;
          end else if (start_rf_o) begin
            state <= SQ_CBR1;
          end
        end
        SQ_ROW:  state <= SQ_COL;
        SQ_COL:  state <= SQ_IDLE;
        SQ_CBR1: state <= SQ_CBR2;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    addr_o   = '0;
    ras_n_o  = 1'b1;
    cas_n_o  = 1'b1;
    we_n_o   = 1'b1;
    lut_rd_o = 1'b0;
    case (state)
      SQ_ROW: begin
        addr_o  = AW'(cur_row);
        ras_n_o = 1'b0;
      end
      SQ_COL: begin
        addr_o   = AW'(cur_col);
        ras_n_o  = 1'b0;
        cas_n_o  = 1'b0;
        we_n_o   = !cur_wr;
        lut_rd_o = !cur_wr;
      end
      SQ_CBR1: cas_n_o = 1'b0;
      SQ_CBR2: begin
        cas_n_o = 1'b0;
        ras_n_o = 1'b0;
      end
      default: ;
    endcase
  end

  p_row_then_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && cas_n_o) |=> (!ras_n_o && !cas_n_o));
  p_cbr_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && ras_n_o) |=> (!ras_n_o && !cas_n_o && we_n_o));
  p_we_in_col_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_o || lut_rd_o) |-> (!ras_n_o && !cas_n_o && $past(!ras_n_o && cas_n_o)));
  p_read_keeps_we_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_rd_o |-> we_n_o);
  p_no_pend_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(kept_i && pix_pend && !start_pix_o));

endmodule

// File: rtl/vid_ref_seq.sv
module vid_ref_seq #(
  parameter int HDIV = 4,
  parameter int VDIV = 4,
  parameter int COLW = 8,
  parameter int ROWW = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   pix_valid_i,
  input  logic                                   hsync_i,
  input  logic                                   vsync_i,
  input  logic                                   ref_req_i,
  output logic [((COLW > ROWW) ? COLW : ROWW)-1:0] dram_addr_o,
  output logic                                   dram_ras_n_o,
  output logic                                   dram_cas_n_o,
  output logic                                   dram_we_n_o,
  output logic                                   lut_rd_o,
  output logic                                   ref_busy_o
);
  localparam int AW = (COLW > ROWW) ? COLW : ROWW;

  logic            kept;
  logic [COLW-1:0] samp_col;
  logic [ROWW-1:0] samp_row;
  logic            wr_frame;
  logic            start_pix, start_rf;

  vrs_scan_ctr #(.HDIV(HDIV), .VDIV(VDIV), .COLW(COLW), .ROWW(ROWW)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .kept_o      (kept),
    .col_o       (samp_col),
    .row_o       (samp_row)
  );

  vrs_ref_ctl u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .ref_req_i  (ref_req_i),
    .wr_frame_o (wr_frame)
  );

  vrs_dram_seq #(.COLW(COLW), .ROWW(ROWW), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kept_i      (kept),
    .col_i       (samp_col),
    .row_i       (samp_row),
    .wr_i        (wr_frame),
    .hsync_i     (hsync_i),
    .addr_o      (dram_addr_o),
    .ras_n_o     (dram_ras_n_o),
    .cas_n_o     (dram_cas_n_o),
    .we_n_o      (dram_we_n_o),
    .lut_rd_o    (lut_rd_o),
    .start_pix_o (start_pix),
    .start_rf_o  (start_rf)
  );

  assign ref_busy_o = wr_frame;

  // R8: the sequencer never launches a refresh and a pixel access together
  p_single_launch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_pix && start_rf));
  // R3: a launched pixel access opens with a row phase on the pins
  p_launch_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pix |=> (!dram_ras_n_o && dram_cas_n_o));

endmodule

// File: tb/test_vid_ref_seq.sv
`timescale 1ns/1ps
module test_vid_ref_seq;
  localparam int HD = 4;
  localparam int VD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pv = 1'b0, hs = 1'b0, vs = 1'b0, rq = 1'b0;
  logic [7:0] addr;
  logic       ras_n, cas_n, we_n, lut, busy;

  int total = 0, bad = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_ref_seq i_vid_ref_seq (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pv), .hsync_i(hs), .vsync_i(vs),
    .ref_req_i(rq), .dram_addr_o(addr), .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n),
    .dram_we_n_o(we_n), .lut_rd_o(lut), .ref_busy_o(busy)
  );

  // behavioural reference model
  typedef struct { int r; int c; bit w; } acc_t;
  acc_t q[$];
  int   m_hc, m_vc, m_ph, m_r, m_c;
  bit   m_w, m_rf, m_arm, m_wr;
  int   n_hsync, n_rf_model, n_rf_pins;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_hc = 0; m_vc = 0; m_ph = 0; m_r = 0; m_c = 0;
      m_w = 0; m_rf = 0; m_arm = 0; m_wr = 0;
    end else begin
      case (m_ph)
        1: m_ph = 2;
        2: m_ph = 0;
        3: m_ph = 4;
        4: m_ph = 0;
        default: begin
          if (q.size() > 0) begin
            acc_t a;
            a = q.pop_front();
            m_r = a.r; m_c = a.c; m_w = a.w; m_ph = 1;
          end else if (m_rf) begin
            m_rf = 0; m_ph = 3; n_rf_model++;
          end
        end
      endcase
      if (hs) begin m_rf = 1; n_hsync++; end
      if (pv && !hs && !vs && (m_hc % HD == 0) && (m_vc % VD == 0)) begin
        acc_t a;
        a.r = (m_vc / VD) % 256; a.c = (m_hc / HD) % 256; a.w = m_wr;
        q.push_back(a);
      end
      if (vs) begin m_hc = 0; m_vc = 0; end
      else if (hs) begin m_hc = 0; m_vc++; end
      else if (pv) m_hc++;
      if (vs) begin m_wr = m_arm; m_arm = rq; end
      else if (rq) m_arm = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started) begin
      bit    e_ras, e_cas, e_we, e_lut;
      string t;
      e_ras = !(m_ph == 1 || m_ph == 2 || m_ph == 4);
      e_cas = !(m_ph == 2 || m_ph == 3 || m_ph == 4);
      e_we  = !(m_ph == 2 && m_w);
      e_lut = (m_ph == 2) && !m_w;
      case (m_ph)
        1: t = "R3";
        2: t = "R4";
        3, 4: t = "R7";
        default: t = "R10";
      endcase
      if (m_rf && (m_ph == 1 || m_ph == 2)) t = "R8";
      chk(ras_n == e_ras, {t, " ras_n"}, int'(ras_n), int'(e_ras));
      chk(cas_n == e_cas, {t, " cas_n"}, int'(cas_n), int'(e_cas));
      chk(we_n == e_we, (m_ph == 2) ? (m_w ? "R6 we_n" : "R5 we_n") : "R10 we_n",
          int'(we_n), int'(e_we));
      chk(lut == e_lut, (m_ph == 2) ? (m_w ? "R6 lut_rd" : "R5 lut_rd") : "R10 lut_rd",
          int'(lut), int'(e_lut));
      chk(busy == m_wr, "R9 ref_busy", int'(busy), int'(m_wr));
      if (m_ph == 1) chk(int'(addr) == m_r, "R2 row address", int'(addr), m_r);
      if (m_ph == 2) chk(int'(addr) == m_c, "R2 column address", int'(addr), m_c);
      if (!cas_n && ras_n) n_rf_pins++;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_line(input int npix, input bit gaps);
    for (int p = 0; p < npix; p++) begin
      pv = 1'b1; tick(); pv = 1'b0;
      if (gaps) begin
        int g;
        g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) tick();
      end
    end
    hs = 1'b1; tick(); hs = 1'b0;
    for (int k = 0; k < 6; k++) tick();
  endtask

  task automatic do_frame(input int nl, input int npix, input bit gaps,
                          input bit req_vs, input int req_line);
    vs = 1'b1; rq = req_vs; tick(); vs = 1'b0; rq = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    for (int l = 0; l < nl; l++) begin
      if (l == req_line) begin rq = 1'b1; tick(); rq = 1'b0; end
      do_line(npix, gaps);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    n_hsync = 0; n_rf_model = 0; n_rf_pins = 0;
    repeat (3) tick();
    // R1: reset state on the pins
    chk(ras_n && cas_n && we_n, "R1 strobes high", int'({ras_n, cas_n, we_n}), 7);
    chk(!lut && !busy, "R1 lut/busy low", int'({lut, busy}), 0);
    rst_n = 1'b1;
    tick();
    chk(ras_n && cas_n && we_n && !lut && !busy, "R1 after reset",
        int'({ras_n, cas_n, we_n, lut, busy}), 28);
    started = 1'b1;
    do_frame(9, 16, 1'b0, 1'b0, -1);   // read frame
    do_frame(9, 16, 1'b0, 1'b0, 3);    // request mid-frame (R9)
    do_frame(9, 16, 1'b0, 1'b0, -1);   // capture frame (R6)
    do_frame(5, 12, 1'b0, 1'b1, -1);   // request with frame sync
    do_frame(9, 20, 1'b1, 1'b0, -1);   // armed frame, gaps in pixels (R2)
    do_frame(9, 5, 1'b0, 1'b0, -1);    // line sync during access (R8)
    do_frame(13, 9, 1'b1, 1'b0, -1);
    vs = 1'b1; tick(); vs = 1'b0;
    repeat (8) tick();
    // R8: no refresh lost to collisions; pins match line syncs
    chk(n_rf_pins == n_hsync, "R8 refresh count", n_rf_pins, n_hsync);
    chk(n_rf_model == n_hsync, "R7 refresh per line", n_rf_model, n_hsync);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule